// File: doc/BRIEF.md
# Open-Drain Clock/Data Pin Pair Register

This block is one 32-bit control word that lets software bit-bang a two-wire serial bus over a clock pin and a data pin. Each pin has a stored direction bit, a stored output level bit and a read-only input bit. The input bit shows the pad level after a synchronizer. A line is released high by switching its pin to input, so the external pull-up raises it. A line is pulled low by switching the pin to output with a stored level of 0. All protocol sequencing stays in software. The block only holds pin state and reports pad levels.

Every write carries its own enable bits. A stored direction bit takes the written value only when its direction-enable bit is set in the same word. A stored level bit takes the written value only when its level-enable bit is set. Software can therefore move one line without reading and rewriting the other. Each pin also has a pull-up-disable bit. These two bits are loaded from every write and are not gated by the enable bits, so software writes back the values it last read.

Each pin owns a 6-bit field that starts at a parameterised base: `CLK_BASE` (default 0) for the clock pin and `DAT_BASE` (default 8) for the data pin. The bit offsets within a field are: 0 pull-up disable, 1 direction enable, 2 direction (1 = output), 3 level enable, 4 output level, 5 input (read-only).

Top module: `od_gpio_pair`

## Requirements
- R1: After reset both pins are inputs (`clkOe`/`datOe` low), both stored levels are 0, both pull-up-disable outputs are 0, and every writable bit of `rdData` reads 0.
- R2: A pin's direction bit (field offset 2, 1 = output) changes on a write only if that pin's direction-enable bit (offset 1) is set in the same write. Otherwise it keeps its value.
- R3: A pin's output level bit (offset 4) changes on a write only if that pin's level-enable bit (offset 3) is set in the same write. Otherwise it keeps its value.
- R4: Writing direction 0 with direction-enable set releases the pin: its output enable goes low on the clock edge that takes the write.
- R5: Writing direction 1 and level 0 with both enables set drives the pin low: output enable high and output level low after that edge.
- R6: A pin's input bit (offset 5) reads the pad level `SYNC_STAGES` clock edges after the pad changes. Writes to that bit have no effect.
- R7: Each pull-up-disable bit (offset 0) takes the written value on every write, whatever the enable bits hold, and drives `clkPullDis`/`datPullDis`.
- R8: Direction-enable and level-enable bits always read back as 0.
- R9: A write whose enable bits address only one pin leaves the other pin's direction and level unchanged.
- R10: With `wrEn` low, no stored bit changes, whatever `wrData` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe for the control word |
| wrData | input | DATA_W | Word written when `wrEn` is high |
| rdData | output | DATA_W | Current control word with input bits; enable bits read 0 |
| clkPadIn | input | 1 | Clock pad level |
| datPadIn | input | 1 | Data pad level |
| clkOe | output | 1 | Clock pad output enable (1 = drive) |
| clkOut | output | 1 | Clock pad output level |
| datOe | output | 1 | Data pad output enable (1 = drive) |
| datOut | output | 1 | Data pad output level |
| clkPullDis | output | 1 | Clock pad pull-up disable |
| datPullDis | output | 1 | Data pad pull-up disable |

## Verification
The bench builds the block with its defaults: `DATA_W` 32, `SYNC_STAGES` 2, clock field at bit 0 and data field at bit 8. With these fields, any single bit set in a clock-pin write cannot alias into the data field, so a write aimed at one pin is a clear test of cross-pin isolation. With two synchronizer stages, the bench can sample the input bit after exactly one edge and after two edges. This separates correct latency from a stage that is missing or extra.

// File: rtl/od_gpio_pkg.sv
package od_gpio_pkg;

  // Bit offsets inside one pin's field
  localparam int OFS_PULL  = 0;
  localparam int OFS_DIRM  = 1;
  localparam int OFS_DIR   = 2;
  localparam int OFS_VALM  = 3;
  localparam int OFS_VAL   = 4;
  localparam int OFS_IN    = 5;
  localparam int FIELD_W   = 6;

  localparam int NUM_PINS  = 2;
  localparam int PIN_CLK   = 0;
  localparam int PIN_DAT   = 1;

  // Strobes from the write decoder to the storage
  typedef struct packed {
    logic [NUM_PINS-1:0] dirLoad;
    logic [NUM_PINS-1:0] dirNext;
    logic [NUM_PINS-1:0] valLoad;
    logic [NUM_PINS-1:0] valNext;
    logic                pullLoad;
    logic [NUM_PINS-1:0] pullNext;
  } ctrl_strobe_t;

endpackage

// File: rtl/od_gpio_sync.sv
module od_gpio_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageQ <= '0;
    end else begin
      stageQ[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) begin
        stageQ[i] <= stageQ[i-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/od_gpio_ctrl.sv
module od_gpio_ctrl
  import od_gpio_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CLK_BASE = 0,
  parameter int DAT_BASE = 8
) (
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output ctrl_strobe_t      strobe
);

  logic [NUM_PINS-1:0] dirLoadV, dirNextV, valLoadV, valNextV, pullNextV;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    localparam int BASE = (p == PIN_CLK) ? CLK_BASE : DAT_BASE;
    assign dirLoadV[p]  = wrEn & wrData[BASE + OFS_DIRM];
    assign dirNextV[p]  = wrData[BASE + OFS_DIR];
    assign valLoadV[p]  = wrEn & wrData[BASE + OFS_VALM];
    assign valNextV[p]  = wrData[BASE + OFS_VAL];
    assign pullNextV[p] = wrData[BASE + OFS_PULL];
  end

  always_comb begin
    strobe.dirLoad  = dirLoadV;
    strobe.dirNext  = dirNextV;
    strobe.valLoad  = valLoadV;
    strobe.valNext  = valNextV;
    strobe.pullLoad = wrEn;
    strobe.pullNext = pullNextV;
  end

endmodule

// File: rtl/od_gpio_dpath.sv
module od_gpio_dpath
  import od_gpio_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CLK_BASE    = 0,
  parameter int DAT_BASE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strobe_t        strobe,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] pinOe,
  output logic [NUM_PINS-1:0] pinOut,
  output logic [NUM_PINS-1:0] pinPullDis,
  output logic [DATA_W-1:0]   rdData
);

  logic [NUM_PINS-1:0] dirQ, valQ, pullQ, inSync;

  od_gpio_sync #(.WIDTH(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (padIn),
    .syncOut (inSync)
  );

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dirQ[p]  <= 1'b0;
        valQ[p]  <= 1'b0;
        pullQ[p] <= 1'b0;
      end else begin
        if (strobe.dirLoad[p]) dirQ[p]  <= strobe.dirNext[p];
        if (strobe.valLoad[p]) valQ[p]  <= strobe.valNext[p];
        if (strobe.pullLoad)   pullQ[p] <= strobe.pullNext[p];
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PINS; p++) begin
      int base;
      base = (p == PIN_CLK) ? CLK_BASE : DAT_BASE;
      rdData[base + OFS_PULL] = pullQ[p];
      rdData[base + OFS_DIR]  = dirQ[p];
      rdData[base + OFS_VAL]  = valQ[p];
      rdData[base + OFS_IN]   = inSync[p];
    end
  end

  assign pinOe      = dirQ;
  assign pinOut     = valQ;
  assign pinPullDis = pullQ;

endmodule

// File: rtl/od_gpio_pair.sv
module od_gpio_pair
  import od_gpio_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int CLK_BASE    = 0,
  parameter int DAT_BASE    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              clkPadIn,
  input  logic              datPadIn,
  output logic              clkOe,
  output logic              clkOut,
  output logic              datOe,
  output logic              datOut,
  output logic              clkPullDis,
  output logic              datPullDis
);

  ctrl_strobe_t        strobe;
  logic [NUM_PINS-1:0] pinOe, pinOut, pinPullDis;

  od_gpio_ctrl #(.DATA_W(DATA_W), .CLK_BASE(CLK_BASE), .DAT_BASE(DAT_BASE)) i_ctrl (
    .wrEn   (wrEn),
    .wrData (wrData),
    .strobe (strobe)
  );

  od_gpio_dpath #(
    .DATA_W(DATA_W), .CLK_BASE(CLK_BASE), .DAT_BASE(DAT_BASE), .SYNC_STAGES(SYNC_STAGES)
  ) i_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .padIn      ({datPadIn, clkPadIn}),
    .pinOe      (pinOe),
    .pinOut     (pinOut),
    .pinPullDis (pinPullDis),
    .rdData     (rdData)
  );

  assign clkOe      = pinOe[PIN_CLK];
  assign clkOut     = pinOut[PIN_CLK];
  assign datOe      = pinOe[PIN_DAT];
  assign datOut     = pinOut[PIN_DAT];
  assign clkPullDis = pinPullDis[PIN_CLK];
  assign datPullDis = pinPullDis[PIN_DAT];

endmodule

// File: rtl/od_gpio_pair_chk.sv
module od_gpio_pair_chk
  import od_gpio_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CLK_BASE = 0,
  parameter int DAT_BASE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [DATA_W-1:0] rdData,
  input logic              clkOe,
  input logic              clkOut,
  input logic              datOe,
  input logic              datOut,
  input logic              clkPullDis,
  input logic              datPullDis
);

  // R2
  clk_dir_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[CLK_BASE + OFS_DIRM]) |=> $stable(clkOe));

  // R3
  dat_val_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !wrData[DAT_BASE + OFS_VALM]) |=> $stable(datOut));

  // R5
  clk_drive_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData[CLK_BASE + OFS_DIRM] && wrData[CLK_BASE + OFS_DIR] &&
     wrData[CLK_BASE + OFS_VALM] && !wrData[CLK_BASE + OFS_VAL]) |=> (clkOe && !clkOut));

  // R7
  pull_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (clkPullDis == $past(wrData[CLK_BASE + OFS_PULL]) &&
              datPullDis == $past(wrData[DAT_BASE + OFS_PULL])));

  // R8
  mask_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdData[CLK_BASE + OFS_DIRM] == 1'b0 && rdData[CLK_BASE + OFS_VALM] == 1'b0 &&
     rdData[DAT_BASE + OFS_DIRM] == 1'b0 && rdData[DAT_BASE + OFS_VALM] == 1'b0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(clkOe) && $stable(clkOut) && $stable(datOe) && $stable(datOut) &&
               $stable(clkPullDis) && $stable(datPullDis)));

endmodule

bind od_gpio_pair od_gpio_pair_chk #(
  .DATA_W(DATA_W), .CLK_BASE(CLK_BASE), .DAT_BASE(DAT_BASE)
) i_chk (.*);

// File: tb/test_od_gpio_pair.sv
`timescale 1ns/1ps
module test_od_gpio_pair;

  localparam int CB = 0;
  localparam int DB = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        clkPadIn = 1'b0, datPadIn = 1'b0;
  logic        clkOe, clkOut, datOe, datOut, clkPullDis, datPullDis;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  od_gpio_pair i_od_gpio_pair (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .clkPadIn(clkPadIn), .datPadIn(datPadIn),
    .clkOe(clkOe), .clkOut(clkOut), .datOe(datOe), .datOut(datOut),
    .clkPullDis(clkPullDis), .datPullDis(datPullDis)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Compare every output against an explicit expected pin state
  task automatic chkAll(input string req,
                        input logic cDir, input logic cVal, input logic cPull, input logic cIn,
                        input logic dDir, input logic dVal, input logic dPull, input logic dIn);
    logic [31:0] e;
    e = '0;
    e[CB+0] = cPull; e[CB+2] = cDir; e[CB+4] = cVal; e[CB+5] = cIn;
    e[DB+0] = dPull; e[DB+2] = dDir; e[DB+4] = dVal; e[DB+5] = dIn;
    chk(req, rdData, e);
    chk(req, {26'd0, clkOe, clkOut, datOe, datOut, clkPullDis, datPullDis},
             {26'd0, cDir, cVal, dDir, dVal, cPull, dPull});
  endtask

  task automatic doWrite(input logic [31:0] w);
    wrEn = 1'b1; wrData = w;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic t_reset();
    chkAll("R1", 0,0,0,0, 0,0,0,0);
  endtask

  task automatic t_drive_low();
    // clock pin: dir enable, dir=1, level enable, level=0
    doWrite(32'h0000_000E);
    chkAll("R5", 1,0,0,0, 0,0,0,0);
    chk("R8", rdData & 32'h0000_0A0A, 32'h0);
    chk("R9", {30'd0, datOe, datOut}, 32'h0);
  endtask

  task automatic t_dir_no_mask();
    // dir=0 but no dir enable: clock stays driven
    doWrite(32'h0000_0000);
    chkAll("R2", 1,0,0,0, 0,0,0,0);
    // data dir=1 without enable
    doWrite(32'h0000_0400);
    chkAll("R2", 1,0,0,0, 0,0,0,0);
  endtask

  task automatic t_release();
    doWrite(32'h0000_0002);
    chkAll("R4", 0,0,0,0, 0,0,0,0);
  endtask

  task automatic t_value_mask();
    doWrite(32'h0000_1800); // data level enable, level=1
    chkAll("R3", 0,0,0,0, 0,1,0,0);
    doWrite(32'h0000_0000 | (32'h1 << (DB+2))); // level 0, no level enable
    chkAll("R3", 0,0,0,0, 0,1,0,0);
    doWrite(32'h0000_0800); // level 0 with enable
    chkAll("R3", 0,0,0,0, 0,0,0,0);
  endtask

  task automatic t_isolation();
    doWrite(32'h0000_0E00); // drive data low only
    chkAll("R9", 0,0,0,0, 1,0,0,0);
    doWrite(32'h0000_001E); // clock: dir out, level 1
    chkAll("R9", 1,1,0,0, 1,0,0,0);
  endtask

  task automatic t_idle();
    wrEn = 1'b0; wrData = 32'hFFFF_FFFF;
    @(negedge clk); @(negedge clk);
    wrData = '0;
    chkAll("R10", 1,1,0,0, 1,0,0,0);
  endtask

  task automatic t_pullup();
    doWrite(32'h0000_0101);
    chkAll("R7", 1,1,1,0, 1,0,1,0);
    doWrite(32'h0000_0100);
    chkAll("R7", 1,1,0,0, 1,0,1,0);
    doWrite(32'h0000_0000);
    chkAll("R7", 1,1,0,0, 1,0,0,0);
  endtask

  task automatic t_input();
    clkPadIn = 1'b1;
    @(negedge clk);
    chk("R6", rdData[CB+5], 1'b0);
    @(negedge clk);
    chk("R6", rdData[CB+5], 1'b1);
    datPadIn = 1'b1;
    @(negedge clk); @(negedge clk);
    chkAll("R6", 1,1,0,1, 1,0,0,1);
    datPadIn = 1'b0;
    doWrite(32'h0000_2020); // input bits written 1: no effect
    @(negedge clk);
    chkAll("R6", 1,1,0,1, 1,0,0,0);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_drive_low();
    t_dir_no_mask();
    t_release();
    t_value_mask();
    t_isolation();
    t_idle();
    t_pullup();
    t_input();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule